// File: doc/BRIEF.md
# SPI Slave Word Engine with Event Flags

This block is a single-channel SPI slave for an on-chip register bus. An external master drives chip select (active low), the serial clock and the serial input. The block shifts one word per group of clock pulses in clock mode 0, most significant bit first. The word length is set by a parameter from 4 to 32 bits. All three SPI inputs are brought into the system clock domain through two-flop synchronisers, and their edges are found there. The system clock must run at least four times faster than the serial clock.

Software reaches the block through four word-wide locations. These are a transmit holding register, a receive holding register, an event flag register and an event enable register. Six sticky event flags report progress and faults: the transmit register was consumed, the transmit register was reused without a refresh, a received word has arrived, a received word was overwritten, a word completed, and a word was cut short by chip-select release. A single interrupt line combines the flags that are enabled.

The register port is plain control and has no back-pressure. Every write or read strobe is taken in the cycle it is presented, and read data is valid combinationally for the presented address. Serial data has no flow control either. When software is late, the block reports it through the underflow and overflow flags and never stalls the master.

Top module: `spi_slave_evt`

## Requirements
- R1: After reset the flag register (address 2), the enable register (address 3), the receive register (address 1) and the interrupt output all read 0, and the serial output is low.
- R2: While chip select is high the serial output is held low, and serial clock pulses have no effect: no flag is set and no bit is counted.
- R3: In clock mode 0 the master samples the serial output before each rising serial-clock edge, and it carries the transmit word MSB first. The slave samples the serial input on each rising edge and assembles the word MSB first.
- R4: The bit counter returns to zero whenever chip select falls, so a new selection starts a whole word regardless of any earlier partial word.
- R5: The transmit register (address 0) is copied into the shifter when chip select falls, and again on the falling serial-clock edge that follows a word's last rising edge. Each copy sets the transmit-empty flag (bit 0), and a write to address 0 clears that flag.
- R6: If address 0 was not written since the previous copy, the copy sets the underflow flag (bit 1), and the old contents are shifted out again.
- R7: When a word's last bit is sampled, the word is written to address 1 and the end-of-transfer flag (bit 4) and the receive-full flag (bit 2) are set. A read of address 1 clears receive-full.
- R8: A word that completes while receive-full is set, and is not being read in the same cycle, sets the overflow flag (bit 3). It still replaces the receive register.
- R9: Releasing chip select with a partial word (bit count not zero) sets the abort flag (bit 5). End-of-transfer is not set, and the receive register keeps its previous value.
- R10: Writing ones to address 2 clears the matching flags; a flag raised in the same cycle wins. The interrupt output is high exactly when some flag and its enable bit in address 3 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select from the master, active low |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, low when not selected |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on address 1) |
| reg_addr | input | 2 | Register address: 0 transmit, 1 receive, 2 flags, 3 enables |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| irq | output | 1 | OR of enabled event flags |

## Verification
The assertions assume that every level of the serial clock lasts at least three system clocks. They also assume that chip select changes only while the serial clock is low, and that serial input changes only at falling edges. Under these conditions each synchronised edge is seen once and in order. The stimulus holds every serial level for four system clocks, moves chip select only with the clock low, and updates the serial input together with the falling edge. Register strobes are driven away from the active clock edge, one access per cycle.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
  typedef enum logic [1:0] {
    ADDR_TX   = 2'd0,
    ADDR_RX   = 2'd1,
    ADDR_FLAG = 2'd2,
    ADDR_EN   = 2'd3
  } reg_addr_e;

  localparam int NFLAG  = 6;
  localparam int F_TXE  = 0;
  localparam int F_UNF  = 1;
  localparam int F_RXF  = 2;
  localparam int F_OVF  = 3;
  localparam int F_EOT  = 4;
  localparam int F_ABT  = 5;
endpackage

// File: rtl/spi_evt_sync.sv
module spi_evt_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] r;
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) r <= RST_VAL;
          else        r <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) r <= RST_VAL;
          else        r <= g_stage[s-1].r;
      end
    end
  endgenerate

  assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/spi_evt_shifter.sv
module spi_evt_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n_s,
  input  logic         sck_s,
  input  logic         mosi_s,
  input  logic [W-1:0] tx_data,
  output logic         miso,
  output logic         load_evt,
  output logic         done_evt,
  output logic         abort_evt,
  output logic [W-1:0] rx_word
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic             cs_q, sck_q;
  logic [CNT_W-1:0] bit_cnt;
  logic [W-1:0]     tx_sh, rx_sh;
  logic             sel, start, stop, rise, fall;

  assign sel   = ~cs_n_s;
  assign start = cs_q & ~cs_n_s;
  assign stop  = ~cs_q & cs_n_s;
  assign rise  = sel & ~sck_q & sck_s;
  assign fall  = sel & sck_q & ~sck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      sck_q   <= 1'b0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
    end else begin
      cs_q  <= cs_n_s;
      sck_q <= sck_s;
      if (start) begin
        bit_cnt <= '0;
        tx_sh   <= tx_data;
      end else if (rise) begin
        rx_sh   <= {rx_sh[W-2:0], mosi_s};
        bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
      end else if (fall) begin
        if (bit_cnt == '0) tx_sh <= tx_data;
        else               tx_sh <= tx_sh << 1;
      end
    end
  end

  assign load_evt  = start | (fall & (bit_cnt == '0));
  assign done_evt  = rise & (bit_cnt == LAST);
  assign abort_evt = stop & (bit_cnt != '0);
  assign rx_word   = {rx_sh[W-2:0], mosi_s};
  assign miso      = ~cs_q & tx_sh[W-1];

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (bit_cnt == '0)); // R4
  AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && cs_n_s) |=> $stable(bit_cnt) && $stable(rx_sh)); // R2
endmodule

// File: rtl/spi_evt_regs.sv
module spi_evt_regs
  import spi_evt_pkg::*;
#(
  parameter int W  = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          load_evt,
  input  logic          done_evt,
  input  logic          abort_evt,
  input  logic [W-1:0]  rx_word,
  output logic [W-1:0]  tx_data,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  logic [W-1:0]     tx_reg, rx_reg;
  logic             tx_fresh;
  logic [NFLAG-1:0] flags, en, set_v, clr_v;
  logic             tx_wr, rx_rd, fl_wr, en_wr;

  assign tx_wr = reg_wr && (reg_addr == ADDR_TX);
  assign fl_wr = reg_wr && (reg_addr == ADDR_FLAG);
  assign en_wr = reg_wr && (reg_addr == ADDR_EN);
  assign rx_rd = reg_rd && (reg_addr == ADDR_RX);

  always_comb begin
    set_v        = '0;
    set_v[F_TXE] = load_evt;
    set_v[F_UNF] = load_evt & ~tx_fresh;
    set_v[F_RXF] = done_evt;
    set_v[F_OVF] = done_evt & flags[F_RXF] & ~rx_rd;
    set_v[F_EOT] = done_evt;
    set_v[F_ABT] = abort_evt;
    clr_v        = fl_wr ? reg_wdata[NFLAG-1:0] : '0;
    clr_v[F_TXE] = clr_v[F_TXE] | tx_wr;
    clr_v[F_RXF] = clr_v[F_RXF] | rx_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_reg   <= '0;
      rx_reg   <= '0;
      tx_fresh <= 1'b0;
      flags    <= '0;
      en       <= '0;
    end else begin
      flags <= (flags & ~clr_v) | set_v;
      if (tx_wr) begin
        tx_reg   <= reg_wdata[W-1:0];
        tx_fresh <= 1'b1;
      end else if (load_evt) begin
        tx_fresh <= 1'b0;
      end
      if (done_evt) rx_reg <= rx_word;
      if (en_wr)    en     <= reg_wdata[NFLAG-1:0];
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_TX:   reg_rdata = DW'(tx_reg);
      ADDR_RX:   reg_rdata = DW'(rx_reg);
      ADDR_FLAG: reg_rdata = DW'(flags);
      default:   reg_rdata = DW'(en);
    endcase
  end

  assign tx_data = tx_reg;
  assign irq     = |(flags & en);

  AST_UNF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !tx_fresh) |=> flags[F_UNF]); // R6
  AST_RX_LAND: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (rx_reg == $past(rx_word)) && flags[F_RXF] && flags[F_EOT]); // R7
  AST_OVF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && flags[F_RXF] && !rx_rd) |=> flags[F_OVF]); // R8
  AST_ABORT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> flags[F_ABT] && $stable(rx_reg)); // R9
endmodule

// File: rtl/spi_slave_evt.sv
module spi_slave_evt #(
  parameter int WORD_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [2:0]        pins_s;
  logic              load_evt, done_evt, abort_evt;
  logic [WORD_W-1:0] rx_word, tx_data;

  spi_evt_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs_n, spi_sclk, spi_mosi}), .q(pins_s)
  );

  spi_evt_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(pins_s[2]), .sck_s(pins_s[1]), .mosi_s(pins_s[0]),
    .tx_data(tx_data), .miso(spi_miso),
    .load_evt(load_evt), .done_evt(done_evt), .abort_evt(abort_evt),
    .rx_word(rx_word)
  );

  spi_evt_regs #(.W(WORD_W), .DW(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .load_evt(load_evt), .done_evt(done_evt), .abort_evt(abort_evt),
    .rx_word(rx_word), .tx_data(tx_data), .reg_rdata(reg_rdata), .irq(irq)
  );

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3) && spi_cs_n)
      |-> !spi_miso); // R2
endmodule

// File: tb/spi_slave_evt_test.sv
module spi_slave_evt_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
  logic        spi_miso;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  spi_slave_evt #(.WORD_W(8), .DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {transmit word, word driven by the master}
  localparam logic [15:0] VEC [6] = '{16'hA53C, 16'h00FF, 16'hFF00,
                                      16'h8001, 16'h5AC3, 16'h1E69};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic cs_drive(input logic v);
    spi_cs_n = v;
    wait_clk(6);
  endtask

  task automatic spi_bits(input int n, input logic [7:0] mo, output logic [7:0] mi);
    mi = '0;
    for (int i = 7; i > 7 - n; i--) begin
      spi_mosi = mo[i];
      wait_clk(4);
      mi[i] = spi_miso;
      spi_sclk = 1'b1;
      wait_clk(4);
      spi_sclk = 1'b0;
    end
    wait_clk(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  got;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);

    // R1 reset state
    reg_read(2'd2, d); chk("R1 flags", d, 32'h0);
    reg_read(2'd3, d); chk("R1 enables", d, 32'h0);
    reg_read(2'd1, d); chk("R1 receive", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 miso", {31'b0, spi_miso}, 32'h0);

    // R3 R5 R6 R7 table of words
    for (int k = 0; k < 6; k++) begin
      reg_write(2'd2, 32'h3F);
      reg_write(2'd0, {24'h0, VEC[k][15:8]});
      cs_drive(1'b0);
      spi_bits(8, VEC[k][7:0], got);
      cs_drive(1'b1);
      chk("R3 miso word", {24'h0, got}, {24'h0, VEC[k][15:8]});
      reg_read(2'd2, d);
      chk("R7 flags after word", d, 32'h17);
      reg_read(2'd1, d);
      chk("R3 receive word", d, {24'h0, VEC[k][7:0]});
    end

    // R5 transmit write clears transmit-empty
    reg_write(2'd0, 32'h3C);
    reg_read(2'd2, d);
    chk("R5 txe cleared by write", d & 32'h1, 32'h0);

    // R9 abort after three bits
    reg_write(2'd2, 32'h3F);
    cs_drive(1'b0);
    spi_bits(3, 8'hE0, got);
    cs_drive(1'b1);
    reg_read(2'd2, d);
    chk("R9 abort flag, no eot", d, 32'h21);
    reg_read(2'd1, d);
    chk("R9 receive kept", d, {24'h0, VEC[5][7:0]});

    // R4 restart on new selection, R6 stale reuse
    reg_write(2'd2, 32'h3F);
    cs_drive(1'b0);
    spi_bits(8, 8'h96, got);
    cs_drive(1'b1);
    chk("R6 stale word reshifted", {24'h0, got}, 32'h3C);
    reg_read(2'd2, d);
    chk("R6 underflow flags", d, 32'h17);

    // R8 overflow: keep receive-full set
    reg_write(2'd2, 32'h3B);
    reg_write(2'd0, 32'hA5);
    cs_drive(1'b0);
    spi_bits(8, 8'h5A, got);
    cs_drive(1'b1);
    chk("R3 fresh word", {24'h0, got}, 32'hA5);
    reg_read(2'd2, d);
    chk("R8 overflow flags", d, 32'h1F);
    reg_read(2'd1, d);
    chk("R8 newest word kept", d, 32'h5A);
    reg_read(2'd2, d);
    chk("R7 read clears rx-full", d & 32'h4, 32'h0);

    // R10 interrupt masking and write-one-to-clear
    reg_write(2'd2, 32'h3F);
    reg_write(2'd3, 32'h10);
    reg_read(2'd3, d);
    chk("R10 enable readback", d, 32'h10);
    chk("R10 irq idle", {31'b0, irq}, 32'h0);
    cs_drive(1'b0);
    spi_bits(8, 8'h11, got);
    cs_drive(1'b1);
    chk("R10 irq on eot", {31'b0, irq}, 32'h1);
    reg_write(2'd2, 32'h10);
    chk("R10 irq after clear", {31'b0, irq}, 32'h0);
    reg_read(2'd2, d);
    chk("R10 other flags kept", d, 32'h07);
    reg_read(2'd1, d);

    // R2 clock pulses while deselected
    reg_write(2'd2, 32'h3F);
    spi_bits(8, 8'hFF, got);
    chk("R2 miso low deselected", {24'h0, got}, 32'h0);
    reg_read(2'd2, d);
    chk("R2 no flags deselected", d, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule